// File: doc/BRIEF.md
# Power Rail Sequencer with Progress Codes

This block walks a board through an ordered power-up and a reverse power-down. Each step does one thing. It either switches a rail enable or waits for a power-good flag, and a wait step has a settle delay and a timeout. While it runs, the block shows a two-digit hex progress code for the current step, and a decimal-point flag is lit while a sequencing action is running. When power-up finishes, the block raises an all-power-good signal and a handoff flag so that host firmware can take over.

The host can request a software reset or a power-off while the board is on. A debounced press of the power button starts power-up from the off state or from a fault hold. A press while the board is on is a hardware reset: the block powers down and powers up again. If a wait step times out during power-up, the block powers everything down and then holds a fault code. If a wait step times out during power-down, the block drops every enable at once and holds a different fault code.

Top module: `rail_sequencer`

## Requirements
- R1: After reset the code output is 0x00. The decimal point, every rail enable, all-power-good and handoff are all low.
- R2: A power-up shows codes 0x81, 0x82 and so on up to 0x8F, each one in turn, and then holds 0x90. While 0x90 is held, handoff and all-power-good are high.
- R3: Enable bit 0 is the main supply, bit 1 is core-regulator configure, bit 2 is core-regulator enable, bit 3 is the clock generator and bit 4 is link bus power. Each enable rises in the cycle after its step: bit 0 first shows at 0x83, bit 1 at 0x86, bit 2 at 0x87, bit 3 at 0x8A, and bit 4 with all-power-good at 0x90. An enable stays high until its power-down step.
- R4: Good bit 0 is the main supply, bit 1 memory, bit 2 core, bit 3 bridge, bit 4 graphics, bit 5 standby-derived, bit 6 analog and termination, and bit 7 fan. Each good bit passes through a two-flop synchroniser. A wait step ignores its good bit for SETTLE_CYC cycles after entry, so a wait whose good bit is already valid lasts exactly SETTLE_CYC+1 cycles.
- R5: If a power-up wait step sees no good bit, it lasts SETTLE_CYC+TIMEOUT_CYC+1 cycles. The block then runs codes 0x91 to 0x99 and holds 0xF2 with every enable low.
- R6: A power-down shows codes 0x91 up to 0x99, each one in turn, and then holds 0x99 with every output low. All-power-good falls first (seen at 0x93), then link and clock (0x94), then core enable (0x95), then core configure (0x96), and the main supply falls last (0x98). Steps 0x96 and 0x98 wait for the core good bit and the main good bit to go low.
- R7: If a power-down wait step times out, the next cycle shows 0xF3 with every enable and all-power-good low, and the block holds that state.
- R8: A debounced button press while the board is on shows 0xF0 for one cycle. The block then runs the full power-down and the full power-up and ends back at 0x90.
- R9: A software reset request while the board is on shows 0xF1 for one cycle and then runs the same power cycle.
- R10: If requests arrive in the same cycle while the board is on, the button press wins over the software reset, and the software reset wins over power-off.
- R11: The decimal point is high while a code from 0x81 to 0x8F, from 0x91 to 0x98, or 0xF0/0xF1 is shown. It is low at 0x00, at 0x90 and at the fault holds 0xF2/0xF3.
- R12: Power-off and software reset requests have no effect unless the board is on. A request in the off state or during power-up leaves the code sequence unchanged.
- R13: A button level must stay stable for DEBOUNCE_CYC cycles before it counts, so a shorter pulse is ignored. A press in the off state or in a fault hold starts power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_btn_i | input | 1 | Raw power button level |
| sw_rst_req_i | input | 1 | Host software reset request, synchronous |
| off_req_i | input | 1 | Host power-off request, synchronous |
| pg_i | input | 8 | Power-good and fan-ok flags, asynchronous |
| rail_en_o | output | 5 | Rail enables |
| pwr_ok_o | output | 1 | All power good to host |
| handoff_o | output | 1 | Sequencing done, host in control |
| code_o | output | 8 | Hex progress code |
| dp_o | output | 1 | Decimal point: a sequencing action is running |

## Verification
A software reset request and a power-off request can reach the on state in the same cycle, and the block must pick exactly one of them. The bench drives both inputs on the same falling edge while the board holds 0x90. It then expects the code log to start with 0xF1 and to end back at 0x90 after a full power cycle, and not to stop at 0x99. A second overlap is a timeout that comes due in the same step where the good bit never arrives. There the bench compares the exact step length with SETTLE_CYC+TIMEOUT_CYC+1.

// File: rtl/rail_seq_pkg.sv
`timescale 1ns/1ps
package rail_seq_pkg;
    localparam int NUM_EN   = 5;
    localparam int NUM_PG   = 8;
    localparam int SEL_W    = $clog2(NUM_PG);
    localparam int IDX_W    = 4;
    localparam int UP_LAST  = 14;
    localparam int DN_LAST  = 8;

    localparam int EN_MAIN  = 0;
    localparam int EN_VCFG  = 1;
    localparam int EN_VCORE = 2;
    localparam int EN_CLK   = 3;
    localparam int EN_LINK  = 4;

    localparam int PG_MAIN  = 0;
    localparam int PG_MEM   = 1;
    localparam int PG_CORE  = 2;
    localparam int PG_BRG   = 3;
    localparam int PG_GFX   = 4;
    localparam int PG_STBY  = 5;
    localparam int PG_ANA   = 6;
    localparam int PG_FAN   = 7;

    localparam logic [7:0] CODE_RESET  = 8'h00;
    localparam logic [7:0] CODE_UP0    = 8'h81;
    localparam logic [7:0] CODE_ON     = 8'h90;
    localparam logic [7:0] CODE_DN0    = 8'h91;
    localparam logic [7:0] CODE_DNEND  = 8'h99;
    localparam logic [7:0] CODE_HWRST  = 8'hF0;
    localparam logic [7:0] CODE_SWRST  = 8'hF1;
    localparam logic [7:0] CODE_UPFLT  = 8'hF2;
    localparam logic [7:0] CODE_DNFLT  = 8'hF3;

    typedef enum logic [2:0] {
        ST_OFF, ST_UP, ST_ON, ST_RST, ST_DN, ST_FAULT
    } seq_state_e;

    typedef struct packed {
        logic              is_wait;
        logic [SEL_W-1:0]  pg_sel;
        logic              pg_lvl;
        logic [NUM_EN-1:0] set_en;
        logic              set_ok;
        logic [NUM_EN-1:0] clr_en;
        logic              clr_ok;
        logic              last;
    } step_t;

    function automatic logic [NUM_EN-1:0] en_bit(input int i);
        logic [NUM_EN-1:0] m;
        m = '0;
        m[i] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/rail_seq_sync.sv
`timescale 1ns/1ps
module rail_seq_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[b] <= 1'b0;
                sync_q[b] <= 1'b0;
            end else begin
                meta_q[b] <= async_i[b];
                sync_q[b] <= meta_q[b];
            end
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/rail_seq_debounce.sv
`timescale 1ns/1ps
module rail_seq_debounce #(
    parameter int DEBOUNCE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic press_o
);
    localparam int CW = $clog2(DEBOUNCE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_CYC - 1);

    typedef struct packed {
        logic          stable;
        logic [CW-1:0] cnt;
        logic          press;
    } db_t;

    db_t db_d, db_q;

    always_comb begin
        db_d       = db_q;
        db_d.press = 1'b0;
        if (level_i != db_q.stable) begin
            if (db_q.cnt == LAST) begin
                db_d.stable = level_i;
                db_d.cnt    = '0;
                db_d.press  = level_i;
            end else begin
                db_d.cnt = db_q.cnt + 1'b1;
            end
        end else begin
            db_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) db_q <= '0;
        else        db_q <= db_d;
    end

    assign press_o = db_q.press;
endmodule

// File: rtl/rail_seq_steps.sv
`timescale 1ns/1ps
module rail_seq_steps
    import rail_seq_pkg::*;
(
    input  logic             dn_i,
    input  logic [IDX_W-1:0] idx_i,
    output step_t            info_o
);
    function automatic step_t wait_for(input int sel, input logic lvl);
        step_t s;
        s         = '0;
        s.is_wait = 1'b1;
        s.pg_sel  = SEL_W'(sel);
        s.pg_lvl  = lvl;
        return s;
    endfunction

    always_comb begin
        info_o = '0;
        if (!dn_i) begin
            case (idx_i)
                4'd1:  info_o.set_en = en_bit(EN_MAIN);
                4'd2:  info_o = wait_for(PG_MAIN, 1'b1);
                4'd3:  info_o = wait_for(PG_MEM, 1'b1);
                4'd4:  info_o.set_en = en_bit(EN_VCFG);
                4'd5:  info_o.set_en = en_bit(EN_VCORE);
                4'd7:  info_o = wait_for(PG_CORE, 1'b1);
                4'd8:  info_o.set_en = en_bit(EN_CLK);
                4'd9:  info_o = wait_for(PG_BRG, 1'b1);
                4'd10: info_o = wait_for(PG_GFX, 1'b1);
                4'd11: info_o = wait_for(PG_STBY, 1'b1);
                4'd12: info_o = wait_for(PG_ANA, 1'b1);
                4'd13: info_o = wait_for(PG_FAN, 1'b1);
                4'd14: begin
                    info_o.set_en = en_bit(EN_LINK);
                    info_o.set_ok = 1'b1;
                end
                default: info_o = '0;
            endcase
            info_o.last = (idx_i == IDX_W'(UP_LAST));
        end else begin
            case (idx_i)
                4'd1: info_o.clr_ok = 1'b1;
                4'd2: info_o.clr_en = en_bit(EN_LINK) | en_bit(EN_CLK);
                4'd3: info_o.clr_en = en_bit(EN_VCORE);
                4'd4: info_o.clr_en = en_bit(EN_VCFG);
                4'd5: info_o = wait_for(PG_CORE, 1'b0);
                4'd6: info_o.clr_en = en_bit(EN_MAIN);
                4'd7: info_o = wait_for(PG_MAIN, 1'b0);
                default: info_o = '0;
            endcase
            info_o.last = (idx_i == IDX_W'(DN_LAST));
        end
    end
endmodule

// File: rtl/rail_sequencer.sv
`timescale 1ns/1ps
module rail_sequencer
    import rail_seq_pkg::*;
#(
    parameter int SETTLE_CYC   = 16,
    parameter int TIMEOUT_CYC  = 2000,
    parameter int DEBOUNCE_CYC = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_btn_i,
    input  logic              sw_rst_req_i,
    input  logic              off_req_i,
    input  logic [NUM_PG-1:0] pg_i,
    output logic [NUM_EN-1:0] rail_en_o,
    output logic              pwr_ok_o,
    output logic              handoff_o,
    output logic [7:0]        code_o,
    output logic              dp_o
);
    localparam int CNT_W = $clog2(SETTLE_CYC + TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(SETTLE_CYC + TIMEOUT_CYC);
    localparam logic [CNT_W-1:0] TMO_V  = CNT_W'(TIMEOUT_CYC);

    typedef struct packed {
        seq_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic [CNT_W-1:0]  cnt;
        logic [NUM_EN-1:0] en;
        logic              ok;
        logic              fault_up;
        logic              restart;
        logic [7:0]        hold;
    } seq_t;

    seq_t q, n;

    logic [NUM_PG-1:0] pg_s;
    logic              btn_s;
    logic              press;
    step_t             stp;
    logic              adv;
    logic              tmo;

    rail_seq_sync #(.WIDTH(NUM_PG)) u_pg_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pg_i), .sync_o(pg_s)
    );

    rail_seq_sync #(.WIDTH(1)) u_btn_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pwr_btn_i), .sync_o(btn_s)
    );

    rail_seq_debounce #(.DEBOUNCE_CYC(DEBOUNCE_CYC)) u_btn_db (
        .clk(clk), .rst_n(rst_n), .level_i(btn_s), .press_o(press)
    );

    rail_seq_steps u_steps (
        .dn_i(q.st == ST_DN), .idx_i(q.idx), .info_o(stp)
    );

    always_comb begin
        n   = q;
        adv = 1'b0;
        tmo = 1'b0;
        case (q.st)
            ST_OFF: begin
                if (press) begin
                    n.st      = ST_UP;
                    n.idx     = '0;
                    n.cnt     = LOAD_V;
                    n.restart = 1'b0;
                    n.fault_up = 1'b0;
                end
            end
            ST_UP, ST_DN: begin
                if (!stp.is_wait) begin
                    adv = 1'b1;
                end else if (q.cnt > TMO_V) begin
                    n.cnt = q.cnt - 1'b1;
                end else if (pg_s[stp.pg_sel] == stp.pg_lvl) begin
                    adv = 1'b1;
                end else if (q.cnt == '0) begin
                    tmo = 1'b1;
                end else begin
                    n.cnt = q.cnt - 1'b1;
                end

                if (adv) begin
                    n.en  = (q.en | stp.set_en) & ~stp.clr_en;
                    n.ok  = (q.ok | stp.set_ok) & ~stp.clr_ok;
                    n.idx = q.idx + 1'b1;
                    n.cnt = LOAD_V;
                    if (stp.last) begin
                        n.idx = '0;
                        if (q.st == ST_UP) begin
                            n.st = ST_ON;
                        end else if (q.fault_up) begin
                            n.st   = ST_FAULT;
                            n.hold = CODE_UPFLT;
                        end else if (q.restart) begin
                            n.st      = ST_UP;
                            n.restart = 1'b0;
                        end else begin
                            n.st   = ST_OFF;
                            n.hold = CODE_DNEND;
                        end
                    end
                end

                if (tmo) begin
                    n.idx = '0;
                    n.cnt = LOAD_V;
                    if (q.st == ST_UP) begin
                        n.st       = ST_DN;
                        n.fault_up = 1'b1;
                        n.restart  = 1'b0;
                    end else begin
                        n.st       = ST_FAULT;
                        n.hold     = CODE_DNFLT;
                        n.en       = '0;
                        n.ok       = 1'b0;
                        n.fault_up = 1'b0;
                    end
                end
            end
            ST_ON: begin
                if (press) begin
                    n.st   = ST_RST;
                    n.hold = CODE_HWRST;
                end else if (sw_rst_req_i) begin
                    n.st   = ST_RST;
                    n.hold = CODE_SWRST;
                end else if (off_req_i) begin
                    n.st      = ST_DN;
                    n.idx     = '0;
                    n.cnt     = LOAD_V;
                    n.restart = 1'b0;
                    n.fault_up = 1'b0;
                end
            end
            ST_RST: begin
                n.st      = ST_DN;
                n.idx     = '0;
                n.cnt     = LOAD_V;
                n.restart = 1'b1;
                n.fault_up = 1'b0;
            end
            ST_FAULT: begin
                if (press) begin
                    n.st       = ST_UP;
                    n.idx      = '0;
                    n.cnt      = LOAD_V;
                    n.fault_up = 1'b0;
                    n.restart  = 1'b0;
                end
            end
            default: n.st = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_OFF;
            q.hold <= CODE_RESET;
        end else begin
            q <= n;
        end
    end

    always_comb begin
        case (q.st)
            ST_UP:   code_o = CODE_UP0 + {{(8-IDX_W){1'b0}}, q.idx};
            ST_DN:   code_o = CODE_DN0 + {{(8-IDX_W){1'b0}}, q.idx};
            ST_ON:   code_o = CODE_ON;
            default: code_o = q.hold;
        endcase
    end

    assign dp_o      = (q.st == ST_UP) || (q.st == ST_DN) || (q.st == ST_RST);
    assign handoff_o = (q.st == ST_ON);
    assign rail_en_o = q.en;
    assign pwr_ok_o  = q.ok;
endmodule

// File: rtl/rail_seq_chk.sv
`timescale 1ns/1ps
module rail_seq_chk
    import rail_seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_EN-1:0] rail_en,
    input logic              pwr_ok,
    input logic              handoff,
    input logic [7:0]        code,
    input logic              dp
);
    AST_HANDOFF_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        handoff |-> (code == CODE_ON) && pwr_ok && (&rail_en)); // R2

    AST_UP_CODE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dp && code >= 8'h81 && code <= 8'h8E) |=>
            (code == $past(code)) || (code == $past(code) + 8'd1) || (code == CODE_DN0)); // R2

    AST_OK_NEEDS_RAILS: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_ok |-> (&rail_en)); // R3

    AST_CORE_AFTER_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rail_en[EN_VCORE]) |-> rail_en[EN_VCFG] && rail_en[EN_MAIN]); // R3

    AST_MAIN_DROPS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rail_en[EN_MAIN]) |-> (rail_en[NUM_EN-1:1] == '0) && !pwr_ok); // R6

    AST_DN_FAULT_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (code == CODE_DNFLT) |-> (rail_en == '0) && !pwr_ok); // R7

    AST_DP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (handoff || code == CODE_UPFLT || code == CODE_DNFLT) |-> !dp); // R11

    AST_DP_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        (code >= 8'h81 && code <= 8'h8F) |-> dp); // R11
endmodule

bind rail_sequencer rail_seq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .rail_en(rail_en_o), .pwr_ok(pwr_ok_o),
    .handoff(handoff_o), .code(code_o), .dp(dp_o)
);

// File: tb/rail_sequencer_tb.sv
`timescale 1ns/1ps
module rail_sequencer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int S  = 4;
    localparam int T  = 20;
    localparam int DB = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       btn = 1'b0;
    logic       sw_rst = 1'b0;
    logic       off_req = 1'b0;
    logic [7:0] force_lo = '0;
    logic [7:0] force_hi = '0;
    logic [7:0] model;
    logic [7:0] pg;
    logic [4:0] rail_en;
    logic       pwr_ok, handoff, dp;
    logic [7:0] code;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0] seen_q[$];
    logic [7:0] exp_q[$];
    int         dur[256];
    int         dp_err = 0;
    logic [7:0] last_code = 8'h00;
    logic [5:0] prev_out = '0;
    logic [7:0] rise_code[6];
    logic [7:0] fall_code[6];

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        model    = 8'hFF;
        model[0] = rail_en[0];
        model[2] = rail_en[2];
        pg       = (model & ~force_lo) | force_hi;
    end

    rail_sequencer #(.SETTLE_CYC(S), .TIMEOUT_CYC(T), .DEBOUNCE_CYC(DB)) dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_btn_i(btn), .sw_rst_req_i(sw_rst),
        .off_req_i(off_req), .pg_i(pg), .rail_en_o(rail_en), .pwr_ok_o(pwr_ok),
        .handoff_o(handoff), .code_o(code), .dp_o(dp)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (code != last_code) seen_q.push_back(code);
            last_code = code;
            dur[code] = dur[code] + 1;
            if (((code >= 8'h81 && code <= 8'h8F) || (code >= 8'h91 && code <= 8'h98) ||
                 code == 8'hF0 || code == 8'hF1) && !dp) dp_err++;
            if ((code == 8'h90 || code == 8'hF2 || code == 8'hF3 || code == 8'h00) && dp) dp_err++;
            for (int i = 0; i < 6; i++) begin
                if (!prev_out[i] && {pwr_ok, rail_en}[i]) rise_code[i] = code;
                if (prev_out[i] && !{pwr_ok, rail_en}[i]) fall_code[i] = code;
            end
            prev_out = {pwr_ok, rail_en};
        end
    end

    task automatic step(input int k = 1);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, expv);
        end
    endtask

    task automatic clr_mon();
        seen_q.delete();
        exp_q.delete();
        for (int i = 0; i < 256; i++) dur[i] = 0;
        for (int i = 0; i < 6; i++) begin
            rise_code[i] = 8'h00;
            fall_code[i] = 8'h00;
        end
        dp_err = 0;
    endtask

    task automatic add_up();
        for (int c = 8'h81; c <= 8'h90; c++) exp_q.push_back(8'(c));
    endtask

    task automatic add_dn();
        for (int c = 8'h91; c <= 8'h99; c++) exp_q.push_back(8'(c));
    endtask

    task automatic check_log(input string req);
        bit ok = (seen_q.size() == exp_q.size());
        int bad = -1;
        if (ok) begin
            for (int i = 0; i < exp_q.size(); i++)
                if (bad < 0 && seen_q[i] != exp_q[i]) bad = i;
            ok = (bad < 0);
        end
        if (!ok && bad >= 0) chk(0, req, seen_q[bad], exp_q[bad]);
        else chk(ok, req, seen_q.size(), exp_q.size());
    endtask

    task automatic wait_code(input logic [7:0] c, input string req);
        for (int k = 0; k < 3000; k++) begin
            if (code == c) return;
            step();
        end
        chk(0, req, code, c);
    endtask

    task automatic press_btn();
        btn = 1'b1;
        step(DB + 6);
        btn = 1'b0;
        step(DB + 6);
    endtask

    task automatic pulse(input bit sw, input bit off);
        sw_rst = sw;
        off_req = off;
        step();
        sw_rst = 1'b0;
        off_req = 1'b0;
    endtask

    task automatic t_reset();
        chk(code == 8'h00, "R1 code", code, 8'h00);
        chk({dp, pwr_ok, handoff, rail_en} == '0, "R1 outputs", {dp, pwr_ok, handoff, rail_en}, 0);
    endtask

    task automatic t_glitch();
        clr_mon();
        btn = 1'b1;
        step(3);
        btn = 1'b0;
        step(30);
        chk(code == 8'h00 && seen_q.size() == 0, "R13 short pulse ignored", code, 8'h00);
    endtask

    task automatic t_ignore_off();
        clr_mon();
        pulse(1'b1, 1'b0);
        step(5);
        pulse(1'b0, 1'b1);
        step(10);
        chk(code == 8'h00 && rail_en == '0 && seen_q.size() == 0, "R12 requests in off", code, 8'h00);
    endtask

    task automatic t_power_up();
        clr_mon();
        add_up();
        btn = 1'b1;
        step(DB + 6);
        btn = 1'b0;
        wait_code(8'h85, "R2 reach 0x85");
        pulse(1'b0, 1'b1);
        pulse(1'b1, 1'b0);
        wait_code(8'h90, "R2 reach 0x90");
        step(DB + 6);
        check_log("R2/R12 up sequence");
        chk(handoff && pwr_ok && rail_en == 5'h1F, "R2 on outputs", {handoff, pwr_ok, rail_en}, 7'h7F);
        chk(dur[8'h83] == S + 1, "R4 settle main", dur[8'h83], S + 1);
        chk(dur[8'h8A] == S + 1, "R4 settle bridge", dur[8'h8A], S + 1);
        chk(rise_code[0] == 8'h83 && rise_code[1] == 8'h86 && rise_code[2] == 8'h87,
            "R3 rise main/cfg/core", {rise_code[0], rise_code[1], rise_code[2]}, 24'h838687);
        chk(rise_code[3] == 8'h8A && rise_code[4] == 8'h90 && rise_code[5] == 8'h90,
            "R3 rise clk/link/ok", {rise_code[3], rise_code[4], rise_code[5]}, 24'h8A9090);
        chk(dp_err == 0 && !dp, "R11 decimal point", dp_err, 0);
    endtask

    task automatic t_power_down();
        clr_mon();
        add_dn();
        pulse(1'b0, 1'b1);
        wait_code(8'h99, "R6 reach 0x99");
        step(10);
        check_log("R6 down sequence");
        chk(code == 8'h99 && {dp, pwr_ok, handoff, rail_en} == '0, "R6 off hold",
            {code, dp, pwr_ok, handoff, rail_en}, 16'h9900);
        chk(fall_code[5] == 8'h93 && fall_code[4] == 8'h94 && fall_code[3] == 8'h94,
            "R6 fall ok/link/clk", {fall_code[5], fall_code[4], fall_code[3]}, 24'h939494);
        chk(fall_code[2] == 8'h95 && fall_code[1] == 8'h96 && fall_code[0] == 8'h98,
            "R6 fall core/cfg/main", {fall_code[2], fall_code[1], fall_code[0]}, 24'h959698);
        chk(dur[8'h96] == S + 1 && dur[8'h98] == S + 1, "R6 down waits", dur[8'h96], S + 1);
    endtask

    task automatic t_hw_reset();
        clr_mon();
        exp_q.push_back(8'hF0);
        add_dn();
        add_up();
        press_btn();
        wait_code(8'h90, "R8 back on");
        check_log("R8 hardware reset cycle");
        chk(dur[8'hF0] == 1 && dp_err == 0, "R8/R11 reset code", dur[8'hF0], 1);
    endtask

    task automatic t_sw_reset();
        clr_mon();
        exp_q.push_back(8'hF1);
        add_dn();
        add_up();
        pulse(1'b1, 1'b0);
        step(2);
        wait_code(8'h90, "R9 back on");
        check_log("R9 software reset cycle");
    endtask

    task automatic t_priority();
        clr_mon();
        exp_q.push_back(8'hF1);
        add_dn();
        add_up();
        pulse(1'b1, 1'b1);
        step(2);
        wait_code(8'h90, "R10 back on");
        check_log("R10 sw reset beats power-off");
    endtask

    task automatic t_up_timeout();
        pulse(1'b0, 1'b1);
        wait_code(8'h99, "R6 off before timeout test");
        force_lo = 8'h08;
        clr_mon();
        for (int c = 8'h81; c <= 8'h8A; c++) exp_q.push_back(8'(c));
        add_dn();
        exp_q.push_back(8'hF2);
        press_btn();
        wait_code(8'hF2, "R5 reach 0xF2");
        step(20);
        check_log("R5 up timeout sequence");
        chk(dur[8'h8A] == S + T + 1, "R5 wait length", dur[8'h8A], S + T + 1);
        chk(code == 8'hF2 && rail_en == '0 && !pwr_ok && !dp, "R5 fault hold",
            {code, rail_en, pwr_ok, dp}, 16'hF200);
        force_lo = '0;
        clr_mon();
        add_up();
        press_btn();
        wait_code(8'h90, "R13 press from fault");
        check_log("R13 restart from fault");
    endtask

    task automatic t_dn_timeout();
        force_hi = 8'h04;
        clr_mon();
        for (int c = 8'h91; c <= 8'h96; c++) exp_q.push_back(8'(c));
        exp_q.push_back(8'hF3);
        pulse(1'b0, 1'b1);
        wait_code(8'hF3, "R7 reach 0xF3");
        chk(rail_en == '0 && !pwr_ok, "R7 dark at fault", rail_en, 0);
        step(20);
        check_log("R7 down timeout sequence");
        chk(dur[8'h96] == S + T + 1, "R7 wait length", dur[8'h96], S + T + 1);
        chk(code == 8'hF3 && !dp && rail_en == '0, "R7 fault held", code, 8'hF3);
        force_hi = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog all requirements: act=hung exp=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_glitch();
        t_ignore_off();
        t_power_up();
        t_power_down();
        clr_mon();
        press_btn();
        wait_code(8'h90, "R13 press from off");
        t_hw_reset();
        t_sw_reset();
        t_priority();
        t_up_timeout();
        t_dn_timeout();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule